// File: doc/BRIEF.md
# Square-Root Cascaded Carry-Select Adder

This block adds two unsigned operands and a single carry-in, producing a sum of the operand width and a carry-out. Internally the operand is cut into a chain of segments whose widths grow from the least significant end upward. The lowest segment is a 2-bit ripple adder fed by the external carry-in. Every later segment is a carry-first carry-select stage. Such a stage forms half-sum and half-carry words, then builds two full carry words in parallel: one assumes an incoming carry of zero and the other assumes one. An AND-OR network picks the carry word that matches the real incoming carry, and XOR gates then form the final sum bits. Because the selected carry word exists before the sum, each stage hands its carry-out to the next stage early. This shortens the path along the chain.

The width parameter chooses one of three fixed partitions, listed here from the least significant segment upward:
- 16 bits: 2, 2, 3, 4, 5
- 32 bits: 2, 2, 3, 4, 6, 7, 8
- 64 bits: 2, 2, 3, 4, 6, 7, 8, 9, 11, 12

Any other width value stops elaboration with an error. The sum and carry-out are captured in output registers. Results therefore appear one clock after the operands are sampled. A synchronous active-high reset clears those registers.

Top module: `sqcsa_adder`

## Requirements
- R1: On every rising clock edge with `rst` low, `sum` takes the low WIDTH bits of `a + b + cin`, computed from the operand values sampled at that edge.
- R2: `cout` is updated in the same cycle as `sum` and equals bit WIDTH of the full total `a + b + cin`.
- R3: At a rising edge where `rst` is high, `sum` becomes all zeros and `cout` becomes 0, whatever the operands are.
- R4: The external carry-in enters the lowest (ripple) segment and ripples through every segment. With `a` all ones, `b` zero and `cin` = 1, the result is `sum` = 0 and `cout` = 1. With both operands zero, `sum` equals `cin`.
- R5: A carry produced at any bit position crosses every segment boundary above it. For `a` = 2^k − 1 and `b` = 1, `sum` = 2^k for every k below WIDTH, and the result wraps to zero with `cout` = 1 when k equals WIDTH.
- R6: WIDTH values 16, 32 and 64 each build their fixed segment partition (listed above, lowest segment first), and each width meets R1 and R2.
- R7: When every bit position propagates (the operands are complementary alternating patterns such as 0101… and 1010…), `sum` is all ones with `cout` = 0 for `cin` = 0, and `sum` is zero with `cout` = 1 for `cin` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the lowest segment |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry out of the top segment |

## Verification
Two things can happen in the same cycle: reset, and capture of a new sum. The bench provokes this by holding live, non-zero operands on the inputs while reset is asserted, both at start-up and as a one-cycle pulse in the middle of the run. It judges the result by requiring zeros in the cycle after the pulse and a correct sum in the cycle after that. A second pairing exercises the selection logic in every stage at once. Full-length propagate patterns let a single carry-in value decide every segment's choice in one addition. That case is checked with both carry-in values on all three widths simultaneously.

// File: rtl/sqcsa_pkg.sv
package sqcsa_pkg;

  localparam int MAX_SEGS = 10;

  function automatic bit width_ok(input int total);
    return (total == 16) || (total == 32) || (total == 64);
  endfunction

  function automatic int seg_count(input int total);
    case (total)
      16:      return 5;
      32:      return 7;
      64:      return 10;
      default: return 1;
    endcase
  endfunction

  // width of segment idx, index 0 is the least significant segment
  function automatic int seg_width(input int total, input int idx);
    case (idx)
      0:       return 2;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      4:       return (total == 16) ? 5 : 6;
      5:       return 7;
      6:       return 8;
      7:       return 9;
      8:       return 11;
      9:       return 12;
      default: return 1;
    endcase
  endfunction

  function automatic int seg_base(input int total, input int idx);
    int acc;
    acc = 0;
    for (int j = 0; j < MAX_SEGS; j++) begin
      if (j < idx) acc += seg_width(total, j);
    end
    return acc;
  endfunction

endpackage

// File: rtl/sqcsa_ripple.sv
module sqcsa_ripple #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] cy;

  assign cy[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign s[i]    = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign co = cy[W];
endmodule

// File: rtl/sqcsa_carry_gen.sv
module sqcsa_carry_gen #(
  parameter int W         = 4,
  parameter bit FIXED_CIN = 1'b0
) (
  input  logic [W-1:0] hs,
  input  logic [W-1:0] hc,
  output logic [W-1:0] cw
);
  // bit 0 is simplified using the known carry value
  if (FIXED_CIN) begin : g_one
    assign cw[0] = hc[0] | hs[0];
  end else begin : g_zero
    assign cw[0] = hc[0];
  end

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign cw[i] = hc[i] | (hs[i] & cw[i-1]);
  end
endmodule

// File: rtl/sqcsa_cs_stage.sv
module sqcsa_cs_stage #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] hs;
  logic [W-1:0] hc;
  logic [W-1:0] cand [2];
  logic [W-1:0] csel;

  assign hs = a ^ b;
  assign hc = a & b;

  for (genvar k = 0; k < 2; k++) begin : g_cgen
    sqcsa_carry_gen #(
      .W         (W),
      .FIXED_CIN (k[0])
    ) cgen_i (
      .hs (hs),
      .hc (hc),
      .cw (cand[k])
    );
  end

  // a set bit in the zero-carry word implies the same bit in the one-carry word
  assign csel = cand[0] | ({W{ci}} & cand[1]);

  assign s[0] = hs[0] ^ ci;
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign s[i] = hs[i] ^ csel[i-1];
  end

  assign co = csel[W-1];
endmodule

// File: rtl/sqcsa_adder.sv
module sqcsa_adder #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  import sqcsa_pkg::*;

  localparam int NSEG = seg_count(WIDTH);

  logic [WIDTH-1:0] sum_nx;
  logic             cout_nx;

  if (!width_ok(WIDTH)) begin : g_bad
    $error("sqcsa_adder: WIDTH must be 16, 32 or 64");
    assign sum_nx  = '0;
    assign cout_nx = 1'b0;
  end else begin : g_chain
    logic [NSEG:0] link;
    assign link[0] = cin;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
      localparam int BASE = seg_base(WIDTH, g);
      localparam int SW   = seg_width(WIDTH, g);

      if (g == 0) begin : g_rca
        sqcsa_ripple #(.W(SW)) seg_i (
          .a  (a[BASE +: SW]),
          .b  (b[BASE +: SW]),
          .ci (link[g]),
          .s  (sum_nx[BASE +: SW]),
          .co (link[g+1])
        );
      end else begin : g_csel
        sqcsa_cs_stage #(.W(SW)) seg_i (
          .a  (a[BASE +: SW]),
          .b  (b[BASE +: SW]),
          .ci (link[g]),
          .s  (sum_nx[BASE +: SW]),
          .co (link[g+1])
        );
      end
    end

    assign cout_nx = link[NSEG];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum  <= '0;
      cout <= 1'b0;
    end else begin
      sum  <= sum_nx;
      cout <= cout_nx;
    end
  end
endmodule

// File: rtl/sqcsa_chk.sv
module sqcsa_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic [WIDTH:0] total_q;
  logic           live;
  logic           rst_q;

  always_ff @(posedge clk) begin
    total_q <= {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    live    <= !rst;
    rst_q   <= rst;
  end

  // R1: registered sum matches arithmetic total of previous operands
  a_r1_sum_total: assert property (@(posedge clk) disable iff (rst)
    live |-> sum == total_q[WIDTH-1:0]);

  // R2: carry-out matches the overflow bit
  a_r2_cout_total: assert property (@(posedge clk) disable iff (rst)
    live |-> cout == total_q[WIDTH]);

  // R2: with carry-out the wrapped sum never exceeds operand a
  a_r2_wrap_le: assert property (@(posedge clk) disable iff (rst)
    (live && cout) |-> sum <= $past(a));

  // R2: without carry-out the sum never falls below operand a
  a_r2_nowrap_ge: assert property (@(posedge clk) disable iff (rst)
    (live && !cout) |-> sum >= $past(a));

  // R3: outputs are cleared after a reset edge
  always @(negedge clk) begin
    if (rst_q === 1'b1) begin
      a_r3_reset_clear: assert (sum == '0 && cout == 1'b0);
    end
  end
endmodule

bind sqcsa_adder sqcsa_chk #(.WIDTH(WIDTH)) chk_i (
  .clk  (clk),
  .rst  (rst),
  .a    (a),
  .b    (b),
  .cin  (cin),
  .sum  (sum),
  .cout (cout)
);

// File: tb/sqcsa_adder_tb_top.sv
module sqcsa_adder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a   = '0;
  logic [63:0] b   = '0;
  logic        cin = 1'b0;

  logic [15:0] sum16;
  logic [31:0] sum32;
  logic [63:0] sum64;
  logic        cout16, cout32, cout64;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] q_a [$];
  logic [63:0] q_b [$];
  logic        q_c [$];
  logic        q_r [$];
  string       q_t [$];

  always #4 clk = ~clk;  // 125 MHz

  sqcsa_adder #(.WIDTH(64)) dut_i (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin), .sum(sum64), .cout(cout64));
  sqcsa_adder #(.WIDTH(32)) dut32_i (
    .clk(clk), .rst(rst), .a(a[31:0]), .b(b[31:0]), .cin(cin), .sum(sum32), .cout(cout32));
  sqcsa_adder #(.WIDTH(16)) dut16_i (
    .clk(clk), .rst(rst), .a(a[15:0]), .b(b[15:0]), .cin(cin), .sum(sum16), .cout(cout16));

  task automatic check_one(input string name, input int w,
                           input logic [63:0] got_s, input logic got_c,
                           input logic [63:0] ea, input logic [63:0] eb,
                           input logic ec, input logic er, input string tag);
    logic [63:0] m;
    logic [64:0] t;
    logic [63:0] exp_s;
    logic        exp_c;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    if (er) t = '0;
    else    t = {1'b0, ea & m} + {1'b0, eb & m} + {64'd0, ec};
    exp_s = t[63:0] & m;
    exp_c = t[w];
    checks++;
    if (got_s !== exp_s) begin
      errors++;
      $display("FAIL %s %s sum: got %h expected %h", tag, name, got_s, exp_s);
    end
    checks++;
    if (got_c !== exp_c) begin
      errors++;
      $display("FAIL %s R2 %s cout: got %b expected %b", tag, name, got_c, exp_c);
    end
  endtask

  task automatic compare_pending();
    logic [63:0] ea, eb;
    logic        ec, er;
    string       tg;
    if (q_a.size() == 0) return;
    ea = q_a.pop_front(); eb = q_b.pop_front();
    ec = q_c.pop_front(); er = q_r.pop_front(); tg = q_t.pop_front();
    check_one("R6 w64", 64, sum64, cout64, ea, eb, ec, er, tg);
    check_one("R6 w32", 32, {32'd0, sum32}, cout32, ea, eb, ec, er, tg);
    check_one("R6 w16", 16, {48'd0, sum16}, cout16, ea, eb, ec, er, tg);
  endtask

  task automatic cycle(input logic [63:0] va, input logic [63:0] vb,
                       input logic vc, input logic vr, input string tag);
    @(negedge clk);
    compare_pending();
    a = va; b = vb; cin = vc; rst = vr;
    q_a.push_back(va); q_b.push_back(vb); q_c.push_back(vc);
    q_r.push_back(vr); q_t.push_back(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset with live operands
    for (int i = 0; i < 3; i++) cycle('1, '1, 1'b1, 1'b1, "R3");
    // R4: carry-in entry and full ripple
    cycle('1, '0, 1'b1, 1'b0, "R4");
    cycle('1, '0, 1'b0, 1'b0, "R4");
    cycle('0, '0, 1'b1, 1'b0, "R4");
    cycle('0, '0, 1'b0, 1'b0, "R4");
    // R7: all positions propagate
    cycle({16{4'h5}}, {16{4'ha}}, 1'b0, 1'b0, "R7");
    cycle({16{4'h5}}, {16{4'ha}}, 1'b1, 1'b0, "R7");
    cycle({16{4'ha}}, {16{4'h5}}, 1'b1, 1'b0, "R7");
    // R2: maximal total
    cycle('1, '1, 1'b0, 1'b0, "R2");
    cycle('1, '1, 1'b1, 1'b0, "R2");
    // R5: carry crossing each boundary
    for (int k = 1; k <= 64; k++) begin
      logic [63:0] av;
      av = (k == 64) ? '1 : ((64'd1 << k) - 64'd1);
      cycle(av, 64'd1, 1'b0, 1'b0, "R5");
    end
    // R3: reset pulse in mid-stream, then recovery
    cycle({$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b1, "R3");
    cycle({$urandom, $urandom}, {$urandom, $urandom}, 1'b1, 1'b0, "R1");
    // R1: random operands, both carry-in values
    for (int i = 0; i < 1500; i++) begin
      cycle({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'b0, "R1");
    end
    cycle('0, '0, 1'b0, 1'b0, "R1");
    @(negedge clk);
    compare_pending();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule